// File: doc/BRIEF.md
# Bound Register Move Unit

This unit carries out one move of a bound pair between a small file of bound registers and either another bound register or memory. Each bound register holds a lower bound and an upper bound. The decoder supplies the fields it needs: the direction, the two operand indices, the register-or-memory flag, the extra index bit from the 64-bit prefix, the mode, the lock and address-size override prefixes, the default-size bit, the privilege level, the alignment-check enable and the effective address. A single-cycle `start` launches the operation while `busy` is low.

Register-to-register moves finish in one cycle. Memory moves use a request/acknowledge port that carries one 64-bit beat per acknowledged request. A 64-bit-mode access takes two beats, one at the effective address and one at the effective address plus 8. A legacy-mode access takes one beat at the effective address, with the lower bound in bits 31:0 and the upper bound in bits 63:32. Legality and alignment are decided in the `start` cycle. A fault leaves every register and every memory word untouched. It emits a one-cycle `fault` pulse together with a cause code. Segment, canonical-address and paging problems come in on `extFault`.

Top module: `bndmov_unit`

## Requirements
- R1: With `rmIsMem`=0, direction 0 sets bound[regField] to bound[rmField]. Direction 1 sets bound[rmField] to bound[regField]. Both halves are copied, no memory beat is issued, and `done` pulses in the cycle after `start`.
- R2: A 64-bit-mode load (`longMode`=1, direction 0) issues exactly two read beats, at address EA and then EA+8. The lower bound takes the first beat and the upper bound takes the second.
- R3: A legacy-mode load issues one read beat at address EA. The lower bound becomes bits 31:0 and the upper bound becomes bits 63:32, each zero-extended to 64 bits.
- R4: A 64-bit-mode store writes the lower bound at EA and the upper bound at EA+8. A legacy-mode store writes one beat at EA with the lower bound's bits 31:0 in bits 31:0 and the upper bound's bits 31:0 in bits 63:32.
- R5: `lockPfx`=1 gives cause 1 (invalid opcode) when the destination is not memory, that is, for any load or for a store with `rmIsMem`=0. A locked store to memory is legal.
- R6: With `rmIsMem`=0, cause 1 is raised when the r/m index is 4 or more. In 64-bit mode that index is {`rexB`,`rmField`}; in legacy mode `rexB` is ignored. A memory operand is never checked this way.
- R7: In legacy mode, cause 1 is raised when `addrOvr` equals `defSize`. In 64-bit mode these two inputs have no effect.
- R8: For a memory operand with `alignChk`=1 and `cpl`=3, an effective address with bits 2:0 not all zero gives cause 2 (alignment).
- R9: `extFault`=1 at `start` gives cause 3 for a memory operand and has no effect on a register-to-register move.
- R10: The cause priority is 1, then 2, then 3. A fault pulses `fault` for one cycle with the cause, issues no memory beat and changes no bound register. `faultCause` reads 0 whenever `fault` is low.
- R11: `memReq` stays high with a stable `memAddr` until `memAck`. `busy` is high exactly while `memReq` is. `done` is a one-cycle pulse in the cycle after the last beat is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch one move (taken only when not busy) |
| isStore | input | 1 | 0: r/m operand to bound[regField]; 1: bound[regField] to r/m operand |
| regField | input | 2 | Bound register index from the reg field |
| rmField | input | 3 | r/m field |
| rmIsMem | input | 1 | 1: r/m is memory, 0: r/m is a bound register |
| rexB | input | 1 | Extra r/m index bit (64-bit mode only) |
| longMode | input | 1 | 1: 64-bit mode, 0: legacy mode |
| lockPfx | input | 1 | Lock prefix present |
| addrOvr | input | 1 | Address-size override present |
| defSize | input | 1 | Code segment default-size bit |
| cpl | input | 2 | Current privilege level |
| alignChk | input | 1 | Alignment checking enabled |
| effAddr | input | 64 | Effective address |
| extFault | input | 1 | Address fault detected outside the unit |
| memReq | output | 1 | Memory beat request |
| memWe | output | 1 | Beat is a write |
| memAddr | output | 64 | Beat byte address |
| memWdata | output | 64 | Write data |
| memAck | input | 1 | Beat accepted; read data valid |
| memRdata | input | 64 | Read data |
| busy | output | 1 | Memory access in progress |
| done | output | 1 | Move completed (one cycle) |
| fault | output | 1 | Move rejected (one cycle) |
| faultCause | output | 2 | 1 invalid opcode, 2 alignment, 3 external |

## Verification
A wrong sequencer state shows at the ports within one acknowledge: there is a missing or extra beat, the second beat goes to the wrong address, or `done` comes a cycle early or late. Corrupted bound contents stay hidden until a later store drives them onto `memWdata`. For that reason, every load and every rejected move is followed by a store whose beats are compared word for word. A fault that lets state change shows up through that same readback. A misordered legality check shows up at once as a wrong cause on the single `fault` pulse.

// File: rtl/bndmov_pkg.sv
package bndmov_pkg;

  typedef enum logic [1:0] {
    CAUSE_NONE = 2'd0,
    CAUSE_UD   = 2'd1,
    CAUSE_AC   = 2'd2,
    CAUSE_EXT  = 2'd3
  } faultCause_e;

  // strobes from control to datapath
  typedef struct packed {
    logic copyReg;    // register-to-register copy this cycle
    logic capOps;     // capture index and address for a memory access
    logic latchLo;    // hold first beat of a 64-bit-mode load
    logic commitLoad; // write both bounds of a load
    logic beatHi;     // second beat in progress
    logic isStore;    // captured direction
    logic longMode;   // captured mode
  } bndStrobe_t;

endpackage

// File: rtl/bndmov_ctrl.sv
module bndmov_ctrl
  import bndmov_pkg::*;
#(
  parameter int NUM_BND    = 4,
  parameter int ALIGN_BITS = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  start,
  input  logic                  isStore,
  input  logic [2:0]            rmField,
  input  logic                  rmIsMem,
  input  logic                  rexB,
  input  logic                  longMode,
  input  logic                  lockPfx,
  input  logic                  addrOvr,
  input  logic                  defSize,
  input  logic [1:0]            cpl,
  input  logic                  alignChk,
  input  logic [ALIGN_BITS-1:0] eaLow,
  input  logic                  extFault,
  input  logic                  memAck,
  output bndStrobe_t            stb,
  output logic                  memReq,
  output logic                  memWe,
  output logic                  busy,
  output logic                  done,
  output logic                  fault,
  output logic [1:0]            faultCause
);

  typedef enum logic [1:0] {ST_IDLE, ST_LO, ST_HI} state_e;

  state_e stateQ;
  logic   storeQ, longQ;
  logic   lockBad, rmRegBad, sizeBad, udHit, acHit, extHit, goodStart;
  logic [3:0] rmFull;

  always_comb begin
    rmFull    = {rexB & longMode, rmField};
    rmRegBad  = !rmIsMem && (int'(rmFull) >= NUM_BND);
    lockBad   = lockPfx && (!isStore || !rmIsMem);
    sizeBad   = !longMode && (addrOvr == defSize);
    udHit     = lockBad || rmRegBad || sizeBad;
    acHit     = rmIsMem && alignChk && (cpl == 2'd3) && (|eaLow);
    extHit    = rmIsMem && extFault;
    goodStart = (stateQ == ST_IDLE) && start && !udHit && !acHit && !extHit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ     <= ST_IDLE;
      storeQ     <= 1'b0;
      longQ      <= 1'b0;
      done       <= 1'b0;
      fault      <= 1'b0;
      faultCause <= CAUSE_NONE;
    end else begin
      done       <= 1'b0;
      fault      <= 1'b0;
      faultCause <= CAUSE_NONE;
      case (stateQ)
        ST_IDLE: if (start) begin
          if (udHit) begin
            fault <= 1'b1; faultCause <= CAUSE_UD;
          end else if (acHit) begin
            fault <= 1'b1; faultCause <= CAUSE_AC;
          end else if (extHit) begin
            fault <= 1'b1; faultCause <= CAUSE_EXT;
          end else if (!rmIsMem) begin
            done <= 1'b1;
          end else begin
            stateQ <= ST_LO;
            storeQ <= isStore;
            longQ  <= longMode;
          end
        end
        ST_LO: if (memAck) begin
          if (longQ) stateQ <= ST_HI;
          else begin
            stateQ <= ST_IDLE;
            done   <= 1'b1;
          end
        end
        ST_HI: if (memAck) begin
          stateQ <= ST_IDLE;
          done   <= 1'b1;
        end
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    stb.copyReg    = goodStart && !rmIsMem;
    stb.capOps     = goodStart && rmIsMem;
    stb.latchLo    = (stateQ == ST_LO) && memAck && longQ && !storeQ;
    stb.commitLoad = !storeQ && memAck &&
                     (((stateQ == ST_LO) && !longQ) || (stateQ == ST_HI));
    stb.beatHi     = (stateQ == ST_HI);
    stb.isStore    = storeQ;
    stb.longMode   = longQ;
    memReq         = (stateQ != ST_IDLE);
    memWe          = storeQ;
    busy           = memReq;
  end

endmodule

// File: rtl/bndmov_dp.sv
module bndmov_dp
  import bndmov_pkg::*;
#(
  parameter int BW      = 64,
  parameter int AW      = 64,
  parameter int NUM_BND = 4,
  localparam int IW     = $clog2(NUM_BND),
  localparam int HALF   = BW / 2,
  localparam int BYTES  = BW / 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  bndStrobe_t    stb,
  input  logic          isStore,
  input  logic [IW-1:0] regIdx,
  input  logic [IW-1:0] rmIdx,
  input  logic [AW-1:0] effAddr,
  input  logic [BW-1:0] memRdata,
  output logic [AW-1:0] memAddr,
  output logic [BW-1:0] memWdata
);

  logic [BW-1:0] lbQ [NUM_BND];
  logic [BW-1:0] ubQ [NUM_BND];
  logic [BW-1:0] loQ;
  logic [IW-1:0] regQ;
  logic [AW-1:0] eaQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_BND; i++) begin
        lbQ[i] <= '0;
        ubQ[i] <= '0;
      end
      loQ  <= '0;
      regQ <= '0;
      eaQ  <= '0;
    end else begin
      if (stb.copyReg) begin
        if (isStore) begin
          lbQ[rmIdx] <= lbQ[regIdx];
          ubQ[rmIdx] <= ubQ[regIdx];
        end else begin
          lbQ[regIdx] <= lbQ[rmIdx];
          ubQ[regIdx] <= ubQ[rmIdx];
        end
      end
      if (stb.capOps) begin
        regQ <= regIdx;
        eaQ  <= effAddr;
      end
      if (stb.latchLo) loQ <= memRdata;
      if (stb.commitLoad) begin
        if (stb.longMode) begin
          lbQ[regQ] <= loQ;
          ubQ[regQ] <= memRdata;
        end else begin
          lbQ[regQ] <= {{HALF{1'b0}}, memRdata[HALF-1:0]};
          ubQ[regQ] <= {{HALF{1'b0}}, memRdata[BW-1:HALF]};
        end
      end
    end
  end

  always_comb begin
    memAddr = eaQ + (stb.beatHi ? AW'(BYTES) : AW'(0));
    if (stb.longMode)
      memWdata = stb.beatHi ? ubQ[regQ] : lbQ[regQ];
    else
      memWdata = {ubQ[regQ][HALF-1:0], lbQ[regQ][HALF-1:0]};
  end

endmodule

// File: rtl/bndmov_unit.sv
module bndmov_unit
  import bndmov_pkg::*;
#(
  parameter int BW      = 64,
  parameter int AW      = 64,
  parameter int NUM_BND = 4,
  localparam int IW     = $clog2(NUM_BND),
  localparam int ALIGN_BITS = $clog2(BW / 8)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic          isStore,
  input  logic [IW-1:0] regField,
  input  logic [2:0]    rmField,
  input  logic          rmIsMem,
  input  logic          rexB,
  input  logic          longMode,
  input  logic          lockPfx,
  input  logic          addrOvr,
  input  logic          defSize,
  input  logic [1:0]    cpl,
  input  logic          alignChk,
  input  logic [AW-1:0] effAddr,
  input  logic          extFault,
  output logic          memReq,
  output logic          memWe,
  output logic [AW-1:0] memAddr,
  output logic [BW-1:0] memWdata,
  input  logic          memAck,
  input  logic [BW-1:0] memRdata,
  output logic          busy,
  output logic          done,
  output logic          fault,
  output logic [1:0]    faultCause
);

  bndStrobe_t stb;

  bndmov_ctrl #(.NUM_BND(NUM_BND), .ALIGN_BITS(ALIGN_BITS)) ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .isStore(isStore),
    .rmField(rmField), .rmIsMem(rmIsMem), .rexB(rexB), .longMode(longMode),
    .lockPfx(lockPfx), .addrOvr(addrOvr), .defSize(defSize), .cpl(cpl),
    .alignChk(alignChk), .eaLow(effAddr[ALIGN_BITS-1:0]), .extFault(extFault),
    .memAck(memAck), .stb(stb), .memReq(memReq), .memWe(memWe), .busy(busy),
    .done(done), .fault(fault), .faultCause(faultCause)
  );

  bndmov_dp #(.BW(BW), .AW(AW), .NUM_BND(NUM_BND)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .isStore(isStore),
    .regIdx(regField), .rmIdx(rmField[IW-1:0]), .effAddr(effAddr),
    .memRdata(memRdata), .memAddr(memAddr), .memWdata(memWdata)
  );

endmodule

// File: rtl/bndmov_chk.sv
module bndmov_chk #(
  parameter int AW = 64
) (
  input logic          clk,
  input logic          rstN,
  input logic          memReq,
  input logic          memAck,
  input logic [AW-1:0] memAddr,
  input logic          done,
  input logic          fault,
  input logic [1:0]    faultCause
);

  // R10
  fault_no_mem_chk: assert property (@(posedge clk) disable iff (!rstN)
    fault |-> !memReq);

  // R10
  fault_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    fault |-> faultCause != 2'd0);

  // R10
  quiet_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    !fault |-> faultCause == 2'd0);

  // R11
  done_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !fault && !memReq);

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && $stable(memAddr));

endmodule

bind bndmov_unit bndmov_chk #(.AW(AW)) chk_i (
  .clk(clk), .rstN(rstN), .memReq(memReq), .memAck(memAck),
  .memAddr(memAddr), .done(done), .fault(fault), .faultCause(faultCause)
);

// File: tb/bndmov_unit_tb_top.sv
`timescale 1ns/1ps
module bndmov_unit_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0, isStore = 1'b0, rmIsMem = 1'b0, rexB = 1'b0;
  logic        longMode = 1'b1, lockPfx = 1'b0, addrOvr = 1'b0, defSize = 1'b0;
  logic        alignChk = 1'b0, extFault = 1'b0;
  logic [1:0]  regField = '0, cpl = '0;
  logic [2:0]  rmField = '0;
  logic [63:0] effAddr = '0;
  logic        memReq, memWe, memAck, busy, done, fault;
  logic [63:0] memAddr, memWdata, memRdata;
  logic [1:0]  faultCause;

  always #10 clk = ~clk; // 50 MHz

  bndmov_unit dut_i (
    .clk(clk), .rstN(rstN), .start(start), .isStore(isStore),
    .regField(regField), .rmField(rmField), .rmIsMem(rmIsMem), .rexB(rexB),
    .longMode(longMode), .lockPfx(lockPfx), .addrOvr(addrOvr),
    .defSize(defSize), .cpl(cpl), .alignChk(alignChk), .effAddr(effAddr),
    .extFault(extFault), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memAck(memAck), .memRdata(memRdata), .busy(busy),
    .done(done), .fault(fault), .faultCause(faultCause)
  );

  // memory model: 16 words, ack one cycle after request
  logic [63:0] mem [16];
  logic        ackQ = 1'b0;
  int          beatTotal = 0;
  logic [7:0]  beatLog [64];

  assign memAck   = ackQ;
  assign memRdata = mem[memAddr[6:3]];

  always @(posedge clk) begin
    ackQ <= rstN && memReq && !ackQ;
    if (memReq && memAck) begin
      if (memWe) mem[memAddr[6:3]] <= memWdata;
      beatLog[beatTotal[5:0]] <= memAddr[7:0];
      beatTotal <= beatTotal + 1;
    end
  end

  int checks = 0, fails = 0;

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  typedef struct packed {
    bit       st;
    bit [1:0] rg;
    bit [2:0] rm;
    bit       mem;
    bit       rx;
    bit       lng;
    bit       lock;
    bit       ovr;
    bit       dsz;
    bit [1:0] pl;
    bit       ac;
    bit [7:0] ea;
    bit       ext;
    bit [1:0] exp;
    bit [3:0] req;
  } vec_t;

  task automatic runOp(input vec_t v, output logic [1:0] cause,
                       output bit gotDone, output int beats, output int base);
    @(negedge clk);
    isStore = v.st; regField = v.rg; rmField = v.rm; rmIsMem = v.mem;
    rexB = v.rx; longMode = v.lng; lockPfx = v.lock; addrOvr = v.ovr;
    defSize = v.dsz; cpl = v.pl; alignChk = v.ac; effAddr = {56'd0, v.ea};
    extFault = v.ext; start = 1'b1;
    base = beatTotal;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 20; k++) begin
      if (done || fault) break;
      @(negedge clk);
    end
    cause   = fault ? faultCause : 2'd0;
    gotDone = done;
    beats   = beatTotal - base;
    @(negedge clk);
  endtask

  function automatic vec_t mk(bit st, bit [1:0] rg, bit [2:0] rm, bit m,
                              bit lng, bit [7:0] ea);
    vec_t v = '0;
    v.st = st; v.rg = rg; v.rm = rm; v.mem = m; v.lng = lng; v.ea = ea;
    v.dsz = !lng; // legal address size in legacy mode
    return v;
  endfunction

  // st rg rm mem rx lng lock ovr dsz pl ac ea ext exp req
  localparam vec_t VEC [19] = '{
    '{0,1,0,1,0,1,1,0,0,0,0,8'h70,0,1,5},  // R5 locked load
    '{1,0,0,1,0,1,1,0,0,0,0,8'h70,0,0,5},  // R5 locked store to memory
    '{1,0,1,0,0,1,1,0,0,0,0,8'h00,0,1,5},  // R5 locked store to register
    '{1,0,5,0,0,0,0,0,1,0,0,8'h00,0,1,6},  // R6 legacy index 5
    '{1,0,3,0,1,1,0,0,0,0,0,8'h00,0,1,6},  // R6 64-bit index 11
    '{1,0,4,0,0,1,0,0,0,0,0,8'h00,0,1,6},  // R6 64-bit index 4
    '{1,0,5,1,0,1,0,0,0,0,0,8'h70,0,0,6},  // R6 memory not index-checked
    '{1,0,0,1,0,0,0,0,0,0,0,8'h70,0,1,7},  // R7 ovr=0 dsz=0
    '{1,0,0,1,0,0,0,1,1,0,0,8'h70,0,1,7},  // R7 ovr=1 dsz=1
    '{1,0,0,1,0,0,0,1,0,0,0,8'h70,0,0,7},  // R7 ovr=1 dsz=0 legal
    '{1,0,0,1,0,1,0,0,0,0,0,8'h70,0,0,7},  // R7 ignored in 64-bit mode
    '{1,0,0,1,0,1,0,0,0,3,1,8'h74,0,2,8},  // R8 unaligned cpl3
    '{1,0,0,1,0,1,0,0,0,2,1,8'h74,0,0,8},  // R8 cpl2
    '{1,0,0,1,0,1,0,0,0,3,0,8'h74,0,0,8},  // R8 check off
    '{1,0,0,1,0,1,0,0,0,3,1,8'h78,0,0,8},  // R8 aligned
    '{1,0,0,1,0,1,0,0,0,0,0,8'h70,1,3,9},  // R9 external on memory
    '{1,0,3,0,0,1,0,0,0,0,0,8'h00,1,0,9},  // R9 ignored on register move
    '{0,1,0,1,0,1,1,0,0,3,1,8'h71,1,1,10}, // R10 priority ud
    '{1,0,0,1,0,1,0,0,0,3,1,8'h71,1,2,10}  // R10 priority ac
  };

  localparam logic [63:0] VAL_A = 64'h1111_2222_3333_4444;
  localparam logic [63:0] VAL_B = 64'h5555_6666_7777_8888;
  localparam logic [31:0] VAL_L = 32'h0BAD_F00D;
  localparam logic [31:0] VAL_H = 32'hCAFE_BEEF;

  initial begin : watchdog
    #(20ns * 100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : stim
    logic [1:0] cause;
    bit gd;
    int nb, bs;
    for (int i = 0; i < 16; i++) mem[i] = '0;
    mem[2] = VAL_A; mem[3] = VAL_B; mem[4] = {VAL_H, VAL_L};
    repeat (3) @(negedge clk);
    // R11 reset state
    check(!busy && !done && !fault && !memReq, "R11 reset",
          {60'd0, busy, done, fault, memReq}, 64'd0);
    rstN = 1'b1;
    @(negedge clk);

    // R2 64-bit load bnd0 from 0x10
    runOp(mk(0, 0, 0, 1, 1, 8'h10), cause, gd, nb, bs);
    check(gd && nb == 2, "R2 two beats", 64'(nb), 64'd2);
    check(beatLog[bs[5:0]] == 8'h10 && beatLog[bs[5:0]+1] == 8'h18, "R2 beat addresses",
          {48'd0, beatLog[bs[5:0]], beatLog[bs[5:0]+1]}, 64'h1018);
    // R4 64-bit store bnd0 to 0x40
    runOp(mk(1, 0, 0, 1, 1, 8'h40), cause, gd, nb, bs);
    check(mem[8] == VAL_A, "R4 long store lower", mem[8], VAL_A);
    check(mem[9] == VAL_B, "R4 long store upper", mem[9], VAL_B);

    // R3 legacy load bnd1 from 0x20
    runOp(mk(0, 1, 0, 1, 0, 8'h20), cause, gd, nb, bs);
    check(gd && nb == 1 && beatLog[bs[5:0]] == 8'h20, "R3 one beat",
          64'(nb), 64'd1);
    // R4 legacy store bnd1 to 0x50
    runOp(mk(1, 1, 0, 1, 0, 8'h50), cause, gd, nb, bs);
    check(nb == 1 && mem[10] == {VAL_H, VAL_L}, "R4 legacy store", mem[10], {VAL_H, VAL_L});
    // R3 zero extension seen through a 64-bit store
    runOp(mk(1, 1, 0, 1, 1, 8'h60), cause, gd, nb, bs);
    check(mem[12] == {32'd0, VAL_L}, "R3 zext lower", mem[12], {32'd0, VAL_L});
    check(mem[13] == {32'd0, VAL_H}, "R3 zext upper", mem[13], {32'd0, VAL_H});

    // R1 register load direction: bnd2 <- bnd0
    runOp(mk(0, 2, 0, 0, 1, 8'h00), cause, gd, nb, bs);
    check(gd && nb == 0, "R1 copy done no beats", 64'(nb), 64'd0);
    runOp(mk(1, 2, 0, 1, 1, 8'h00), cause, gd, nb, bs);
    check(mem[0] == VAL_A && mem[1] == VAL_B, "R1 load-direction copy", mem[1], VAL_B);
    // R1 register store direction: bnd3 <- bnd1
    runOp(mk(1, 1, 3, 0, 1, 8'h00), cause, gd, nb, bs);
    runOp(mk(1, 3, 0, 1, 1, 8'h30), cause, gd, nb, bs);
    check(mem[6] == {32'd0, VAL_L} && mem[7] == {32'd0, VAL_H},
          "R1 store-direction copy", mem[7], {32'd0, VAL_H});

    // legality and fault table
    foreach (VEC[i]) begin
      runOp(VEC[i], cause, gd, nb, bs);
      check(cause == VEC[i].exp && (gd == (VEC[i].exp == 2'd0)),
            $sformatf("R%0d vector %0d cause", VEC[i].req, i), {62'd0, cause},
            {62'd0, VEC[i].exp});
      if (VEC[i].exp != 2'd0)
        check(nb == 0, "R10 no beat on fault", 64'(nb), 64'd0);
    end

    // R10 faulted load leaves bnd0 unchanged
    begin
      vec_t v = mk(0, 0, 0, 1, 1, 8'h11);
      v.ac = 1'b1; v.pl = 2'd3;
      runOp(v, cause, gd, nb, bs);
      check(cause == 2'd2 && nb == 0, "R10 ac load rejected", {62'd0, cause}, 64'd2);
    end
    mem[8] = '0; mem[9] = '0;
    runOp(mk(1, 0, 0, 1, 1, 8'h40), cause, gd, nb, bs);
    check(mem[8] == VAL_A && mem[9] == VAL_B, "R10 register unchanged", mem[8], VAL_A);

    // R11 done lasts one cycle; busy tracks the access
    @(negedge clk);
    isStore = 1'b1; regField = 2'd0; rmIsMem = 1'b1; longMode = 1'b1;
    lockPfx = 1'b0; alignChk = 1'b0; extFault = 1'b0; effAddr = 64'h40; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy && memReq, "R11 busy during access", {62'd0, busy, memReq}, 64'd3);
    for (int k = 0; k < 20; k++) begin
      if (done) break;
      @(negedge clk);
    end
    check(done && !busy, "R11 done after last beat", {62'd0, done, busy}, 64'd2);
    @(negedge clk);
    check(!done, "R11 done single cycle", {63'd0, done}, 64'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule